// File: doc/BRIEF.md
# Block-Transfer DMA Channel Sequencer

This block sequences one DMA channel that moves a whole block of data for each transfer request it accepts. A block is between 1 and 256 units long, and a unit is either a byte or a 16-bit word. For every unit the sequencer runs a read bus cycle at the source address and then a write bus cycle at the destination address. The data read is latched and driven back out on the write. Both addresses step after every unit. They keep their values from one block to the next and are never reloaded.

Configuration arrives as a single load strobe that carries three things: the starting addresses with their stepping modes, the unit size and bus-release flag, and a 24-bit count word. The upper 8 bits of the count word give the block length, where 0 means 256 units. The lower 16 bits count the blocks still to be moved. While a block is running, the sequencer holds off higher-priority channels through a hold output. It marks the final write of each block with a block-end strobe. It gives up the bus in the cycle after that write. If the bus-release flag is set, another master can take the bus in the middle of a block. The block then continues at the next unit once the bus is granted back.

Top module: `dma_blk_seq`

## Requirements
- R1: When the channel is enabled and idle, a high `xfer_req` at a clock edge is accepted, and `req_ack` is high for exactly the one following cycle. There is one acknowledge per block.
- R2: Each accepted request produces N read/write unit pairs. N is `cfg_count[23:16]`, with the value 0 meaning 256.
- R3: Each unit is a one-cycle read (`bus_rd`) at the source address. It is followed in the next cycle by a one-cycle write (`bus_wr`) at the destination address. The write drives `bus_wdata` with the `bus_rdata` sampled during the read.
- R4: Each address moves after its write by a step set by its 2-bit mode. Mode 01 adds the unit size, mode 10 subtracts it, and modes 00 and 11 leave the address unchanged. The unit size is 2 when `cfg_word`=1 and 1 otherwise. Addresses are not reloaded between blocks.
- R5: `blk_end` is high only during the write cycle of the last unit of a block.
- R6: `bus_req` rises in the cycle after acceptance. The first read follows the first edge at which `bus_gnt` is high. `bus_req` is low in the cycle after the last write of a block.
- R7: `hold_higher` is high from the cycle after acceptance through the last write of the block.
- R8: With the release flag set, if `other_req` is high at the end of a write that is not the last one in the block, `bus_req` drops and stays low while `other_req` stays high. The sequencer then requests again and resumes with the next unit, and the block still contains N units.
- R9: With the release flag clear, `other_req` has no effect on the sequence.
- R10: The lower 16 count bits go down by one at each block end. When they reach zero, `ch_en` clears, `ch_done` sets, and further requests are ignored. A new load clears `ch_done`.
- R11: After reset all bus strobes, `req_ack`, `blk_end`, `hold_higher`, `ch_en` and `ch_done` are low, and `bus_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load configuration and enable (accepted while idle) |
| cfg_src | input | AW | Starting source address |
| cfg_dst | input | AW | Starting destination address |
| cfg_count | input | 24 | Block size [23:16] and block count [15:0] |
| cfg_src_mode | input | 2 | Source stepping mode |
| cfg_dst_mode | input | 2 | Destination stepping mode |
| cfg_word | input | 1 | 1: 16-bit units, 0: byte units |
| cfg_brel | input | 1 | Allow bus release in mid-block |
| xfer_req | input | 1 | Transfer request |
| bus_gnt | input | 1 | Bus granted to this channel |
| other_req | input | 1 | Another master requests the bus |
| bus_rdata | input | DW | Read data |
| bus_req | output | 1 | Bus request |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_addr | output | AW | Bus address |
| bus_word | output | 1 | Unit is a word |
| bus_wdata | output | DW | Write data |
| req_ack | output | 1 | Request-acknowledge pulse |
| blk_end | output | 1 | Last write of a block |
| hold_higher | output | 1 | Hold higher-priority channels pending |
| ch_en | output | 1 | Channel enabled |
| ch_done | output | 1 | Block count exhausted |

## Verification
Every output is registered state, so a result is due one clock after the edge that causes it. `req_ack` and `bus_req` appear the cycle after acceptance, the first read comes one cycle after a granted edge, and each write follows its read by one cycle. The count and address updates show up one cycle after the write that triggers them. The bench runs a behavioural model that advances on the same edge as the design. It compares all outputs at the falling edge, so every expectation is checked in exactly the cycle it becomes due. Counted scenarios add explicit checks on unit totals, on the pause seen during a release, and on requests ignored once the count is exhausted.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARB   = 3'd1,
    ST_RD    = 3'd2,
    ST_WR    = 3'd3,
    ST_PAUSE = 3'd4
  } seq_st_t;

  // Signed address increment for a stepping mode and unit size.
  function automatic logic [31:0] step_delta(input logic [1:0] mode, input logic word);
    logic [31:0] unit;
    unit = word ? 32'd2 : 32'd1;
    case (mode)
      2'b01:   step_delta = unit;
      2'b10:   step_delta = -unit;
      default: step_delta = 32'd0;
    endcase
  endfunction

  // Units per block from the size field; zero encodes the maximum.
  function automatic logic [8:0] blk_units(input logic [7:0] fld);
    blk_units = (fld == 8'd0) ? 9'd256 : {1'b0, fld};
  endfunction
endpackage

// File: rtl/dbs_addr_unit.sv
module dbs_addr_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic [1:0]    load_mode,
  input  logic          load_word,
  input  logic          step,
  output logic [AW-1:0] addr
);
  import dbs_pkg::*;
  logic [1:0] mode_q;
  logic       word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      mode_q <= 2'b00;
      word_q <= 1'b0;
    end else if (load) begin
      addr   <= load_val;
      mode_q <= load_mode;
      word_q <= load_word;
    end else if (step) begin
      addr <= addr + AW'(step_delta(mode_q, word_q));
    end
  end

  a_r4_fixed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && (mode_q == 2'b00 || mode_q == 2'b11)) |=> $stable(addr));
  a_r4_dec_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mode_q == 2'b10 && addr > AW'(2)) |=> (addr < $past(addr)));
endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl #(
  parameter int SZW  = 8,
  parameter int CNTW = 16,
  localparam int CW  = SZW + CNTW,
  localparam int UW  = SZW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_brel,
  input  logic          xfer_req,
  input  logic          bus_gnt,
  input  logic          other_req,
  output logic          load_ok,
  output logic          unit_step,
  output logic          bus_req,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          req_ack,
  output logic          blk_end,
  output logic          hold_higher,
  output logic          ch_en,
  output logic          ch_done
);
  import dbs_pkg::*;
  seq_st_t         st;
  logic [SZW-1:0]  bsz_q;
  logic [CNTW-1:0] cnt_q;
  logic [UW-1:0]   left_q;
  logic            brel_q;
  logic            accept;
  logic            last_unit;
  logic            release_now;

  assign load_ok     = cfg_load && (st == ST_IDLE);
  assign accept      = (st == ST_IDLE) && ch_en && xfer_req && !cfg_load;
  assign last_unit   = (left_q == UW'(1));
  assign release_now = brel_q && other_req && !last_unit;
  assign unit_step   = (st == ST_WR);
  assign bus_req     = (st == ST_ARB) || (st == ST_RD) || (st == ST_WR);
  assign bus_rd      = (st == ST_RD);
  assign bus_wr      = (st == ST_WR);
  assign blk_end     = (st == ST_WR) && last_unit;
  assign hold_higher = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bsz_q   <= '0;
      cnt_q   <= '0;
      left_q  <= '0;
      brel_q  <= 1'b0;
      req_ack <= 1'b0;
      ch_en   <= 1'b0;
      ch_done <= 1'b0;
    end else begin
      req_ack <= 1'b0;
      if (load_ok) begin
        bsz_q   <= cfg_count[CW-1:CNTW];
        cnt_q   <= cfg_count[CNTW-1:0];
        brel_q  <= cfg_brel;
        ch_en   <= 1'b1;
        ch_done <= 1'b0;
      end
      case (st)
        ST_IDLE: if (accept) begin
          st      <= ST_ARB;
          req_ack <= 1'b1;
          left_q  <= UW'(blk_units(8'(bsz_q)));
        end
        ST_ARB:  if (bus_gnt) st <= ST_RD;
        ST_RD:   st <= ST_WR;
        ST_WR: begin
          left_q <= left_q - UW'(1);
          if (last_unit) begin
            cnt_q <= cnt_q - CNTW'(1);
            if (cnt_q == CNTW'(1)) begin
              ch_en   <= 1'b0;
              ch_done <= 1'b1;
            end
            st <= ST_IDLE;
          end else if (release_now) begin
            st <= ST_PAUSE;
          end else begin
            st <= ST_RD;
          end
        end
        ST_PAUSE: if (!other_req) st <= ST_ARB;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  a_r1_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);
  a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_wr);
  a_r5_end_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |-> bus_wr);
  a_r6_release_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> !bus_req);
  a_r7_hold_while_bus: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> hold_higher);
  a_r8_pause_keeps_off: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_higher && !bus_req && other_req) |=> !bus_req);
  a_r9_no_release_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !blk_end && !brel_q) |=> bus_rd);
  a_r10_done_disables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_done) |-> !ch_en);
endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq #(
  parameter int AW   = 32,
  parameter int DW   = 16,
  parameter int SZW  = 8,
  parameter int CNTW = 16,
  localparam int CW  = SZW + CNTW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_src_mode,
  input  logic [1:0]    cfg_dst_mode,
  input  logic          cfg_word,
  input  logic          cfg_brel,
  input  logic          xfer_req,
  input  logic          bus_gnt,
  input  logic          other_req,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic          bus_word,
  output logic [DW-1:0] bus_wdata,
  output logic          req_ack,
  output logic          blk_end,
  output logic          hold_higher,
  output logic          ch_en,
  output logic          ch_done
);
  localparam int NPTR = 2;
  logic          load_ok;
  logic          unit_step;
  logic [DW-1:0] rbuf_q;
  logic          word_q;
  logic [AW-1:0] ld_val  [NPTR];
  logic [1:0]    ld_mode [NPTR];
  logic [AW-1:0] ptr     [NPTR];

  assign ld_val[0]  = cfg_src;
  assign ld_val[1]  = cfg_dst;
  assign ld_mode[0] = cfg_src_mode;
  assign ld_mode[1] = cfg_dst_mode;

  dbs_ctrl #(.SZW(SZW), .CNTW(CNTW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_count(cfg_count),
    .cfg_brel(cfg_brel), .xfer_req(xfer_req), .bus_gnt(bus_gnt),
    .other_req(other_req), .load_ok(load_ok), .unit_step(unit_step),
    .bus_req(bus_req), .bus_rd(bus_rd), .bus_wr(bus_wr), .req_ack(req_ack),
    .blk_end(blk_end), .hold_higher(hold_higher), .ch_en(ch_en),
    .ch_done(ch_done)
  );

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    dbs_addr_unit #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(load_ok), .load_val(ld_val[i]),
      .load_mode(ld_mode[i]), .load_word(cfg_word), .step(unit_step),
      .addr(ptr[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf_q <= '0;
      word_q <= 1'b0;
    end else begin
      if (load_ok) word_q <= cfg_word;
      if (bus_rd)  rbuf_q <= bus_rdata;
    end
  end

  assign bus_addr  = bus_rd ? ptr[0] : (bus_wr ? ptr[1] : '0);
  assign bus_wdata = rbuf_q;
  assign bus_word  = word_q;

  a_r3_wdata_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (bus_wdata == $past(bus_rdata)));
endmodule

// File: tb/dma_blk_seq_test.sv
module dma_blk_seq_test;
  localparam int CLK_NS = 10;
  localparam int AW = 32;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0, cfg_word = 0, cfg_brel = 0;
  logic [AW-1:0] cfg_src = 0, cfg_dst = 0;
  logic [23:0] cfg_count = 0;
  logic [1:0] cfg_src_mode = 0, cfg_dst_mode = 0;
  logic xfer_req = 0, other_req = 0, gnt_allow = 1;
  logic bus_gnt;
  logic [DW-1:0] bus_rdata;
  logic bus_req, bus_rd, bus_wr, bus_word, req_ack, blk_end, hold_higher, ch_en, ch_done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;

  always #(CLK_NS/2) clk = ~clk;
  assign bus_gnt   = bus_req & gnt_allow;
  assign bus_rdata = bus_addr[15:0] ^ 16'hA5C3;

  dma_blk_seq uut (.*);

  int errs = 0, checks = 0, cyc = 0;

  // Reference model: phase 0 idle, 1 waiting for bus, 2 read, 3 write, 4 yielded.
  int m_phase = 0, m_left = 0, m_size = 0, m_cnt = 0;
  bit m_en = 0, m_done = 0, m_ack = 0, m_brel = 0, m_word = 0;
  int m_smode = 0, m_dmode = 0;
  logic [31:0] m_src = 0, m_dst = 0;
  logic [15:0] m_rbuf = 0;

  function automatic logic [31:0] mv(logic [31:0] a, int mode, bit word);
    int u = word ? 2 : 1;
    if (mode == 1) return a + u;
    if (mode == 2) return a - u;
    return a;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit was_ack = m_ack;
      m_ack = 0;
      if (cfg_load && m_phase == 0) begin
        m_en = 1; m_done = 0; m_size = cfg_count[23:16]; m_cnt = cfg_count[15:0];
        m_brel = cfg_brel; m_word = cfg_word; m_smode = cfg_src_mode;
        m_dmode = cfg_dst_mode; m_src = cfg_src; m_dst = cfg_dst;
      end
      case (m_phase)
        0: if (m_en && xfer_req && !cfg_load) begin
             m_phase = 1; m_ack = 1; m_left = (m_size == 0) ? 256 : m_size;
           end
        1: if (gnt_allow) m_phase = 2;
        2: begin m_rbuf = m_src[15:0] ^ 16'hA5C3; m_phase = 3; end
        3: begin
             m_src = mv(m_src, m_smode, m_word);
             m_dst = mv(m_dst, m_dmode, m_word);
             m_left--;
             if (m_left == 0) begin
               m_cnt = (m_cnt - 1) & 16'hFFFF;
               if (m_cnt == 0) begin m_en = 0; m_done = 1; end
               m_phase = 0;
             end else if (m_brel && other_req) m_phase = 4;
             else m_phase = 2;
           end
        4: if (!other_req) m_phase = 1;
        default: m_phase = 0;
      endcase
      if (was_ack && m_ack) m_ack = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] ea;
      cyc++;
      ea = (m_phase == 2) ? m_src : (m_phase == 3) ? m_dst : 32'd0;
      chk(req_ack == m_ack, "R1 req_ack", req_ack, m_ack);
      chk(bus_rd == (m_phase == 2) && bus_wr == (m_phase == 3), "R2 rd/wr strobes",
          {bus_rd, bus_wr}, {m_phase == 2, m_phase == 3});
      chk(bus_addr == ea, "R4 bus_addr", bus_addr, ea);
      if (m_phase == 3) chk(bus_wdata == m_rbuf, "R3 bus_wdata", bus_wdata, m_rbuf);
      chk(blk_end == (m_phase == 3 && m_left == 1), "R5 blk_end", blk_end, m_phase == 3 && m_left == 1);
      chk(bus_req == (m_phase >= 1 && m_phase <= 3), "R6 R8 bus_req", bus_req, m_phase >= 1 && m_phase <= 3);
      chk(hold_higher == (m_phase != 0), "R7 hold_higher", hold_higher, m_phase != 0);
      chk(ch_en == m_en && ch_done == m_done, "R10 en/done", {ch_en, ch_done}, {m_en, m_done});
      if (cyc > 100000) begin
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
      end
    end
  end

  task automatic load(input logic [31:0] s, d, input logic [1:0] sm, dm,
                      input bit w, b, input logic [7:0] sz, input logic [15:0] n);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_src_mode = sm; cfg_dst_mode = dm;
    cfg_word = w; cfg_brel = b; cfg_count = {sz, n}; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
  endtask

  int rd_cnt, pause_seen, req_cnt;
  always @(negedge clk) begin
    if (bus_rd) rd_cnt++;
    if (bus_req) req_cnt++;
    if (hold_higher && !bus_req && other_req) pause_seen++;
  end

  task automatic block();
    rd_cnt = 0; pause_seen = 0; req_cnt = 0;
    xfer_req = 1;
    @(negedge clk); xfer_req = 0;
    do @(negedge clk); while (m_phase != 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!bus_req && !bus_rd && !bus_wr && !req_ack && !blk_end && !hold_higher
        && !ch_en && !ch_done && bus_addr == 0, "R11 reset state", {bus_req, ch_en}, 0);
    rst_n = 1;
    @(negedge clk);

    // Byte units, source up, destination down, 3 units, 2 blocks.
    load(32'h100, 32'h2000, 2'b01, 2'b10, 0, 0, 8'd3, 16'd2);
    block();
    chk(rd_cnt == 3, "R2 three units", rd_cnt, 3);
    block();
    chk(ch_done && !ch_en, "R10 count exhausted", {ch_done, ch_en}, 2'b10);
    block();
    chk(rd_cnt == 0, "R10 request ignored when done", rd_cnt, 0);

    // Word units, size field 0 = 256 units, fixed source, incrementing destination.
    load(32'h40, 32'h8000, 2'b11, 2'b01, 1, 0, 8'd0, 16'd1);
    block();
    chk(rd_cnt == 256, "R2 size zero is 256", rd_cnt, 256);
    chk(bus_word == 1, "R4 word unit", bus_word, 1);

    // Delayed grant, then release enabled mid-block.
    load(32'h300, 32'h400, 2'b01, 2'b01, 0, 1, 8'd4, 16'd3);
    gnt_allow = 0;
    xfer_req = 1;
    @(negedge clk); xfer_req = 0;
    repeat (3) @(negedge clk);
    gnt_allow = 1;
    do @(negedge clk); while (m_phase != 0);
    @(negedge clk);
    rd_cnt = 0; pause_seen = 0;
    xfer_req = 1;
    @(negedge clk); xfer_req = 0;     // ARB
    @(negedge clk);                   // RD
    @(negedge clk); other_req = 1;    // WR of unit 1
    repeat (3) @(negedge clk);
    other_req = 0;
    do @(negedge clk); while (m_phase != 0);
    chk(pause_seen >= 2, "R8 bus yielded mid-block", pause_seen, 2);
    chk(rd_cnt == 4, "R8 block resumes to full length", rd_cnt, 4);

    // Release disabled: other_req held high has no effect.
    load(32'h500, 32'h600, 2'b10, 2'b00, 1, 0, 8'd4, 16'd1);
    other_req = 1;
    block();
    other_req = 0;
    chk(req_cnt == 9, "R9 other_req ignored", req_cnt, 9);
    chk(pause_seen == 0, "R9 no yield", pause_seen, 0);

    // Continuous request: consecutive blocks with addresses carried over.
    load(32'h10, 32'h20, 2'b01, 2'b01, 0, 0, 8'd2, 16'd3);
    xfer_req = 1;
    repeat (30) @(negedge clk);
    xfer_req = 0;
    chk(ch_done, "R10 done after three blocks", ch_done, 1);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule